// File: doc/BRIEF.md
# Pattern-Driven Fractional Register

This block is a one-slot delay element for a statically scheduled latency-insensitive link. It sits directly after the ordinary link register and in front of a computation node. It has no stop or back-pressure wires. The consumer's firing schedule is fixed ahead of time as an ultimately periodic binary word: a lead-in part that runs once, then a loop part that repeats forever. That schedule can differ from the producer's schedule shifted by one cycle. On each cycle the element either lets a token straight through or parks it in its single slot, so that tokens reach the consumer only on cycles where the schedule says the consumer fires.

Two parameters set the schedule. The lead-in has `LEAD_LEN` letters, taken from `LEAD_PAT`. The loop has `LOOP_LEN` letters, taken from `LOOP_PAT`. Bit i of each pattern holds letter i. A letter of 1 means the downstream node fires in that cycle. The rate of the schedule is the number of 1s in the loop divided by `LOOP_LEN`.

A sequencer state machine has two states. `PH_LEAD` walks the lead-in letters and moves to `PH_LOOP` after the last one. `PH_LOOP` walks the loop letters and wraps back to its first letter. When `LEAD_LEN` is 0 the sequencer starts in `PH_LOOP`. A slot state machine also has two states. `SL_EMPTY` moves to `SL_HELD` when a token arrives on a 0 letter. `SL_HELD` moves back to `SL_EMPTY` when it fires with no new arrival, and stays in `SL_HELD` when it fires while a new token arrives or when the letter is 0.

Top module: `frac_reg`

## Requirements
- R1: While `rst` is high, `out_vld` is low whatever `in_vld` is. Reset empties the slot, and the first cycle after release uses lead-in letter 0.
- R2: The letter for cycle k after reset release is `LEAD_PAT[k]` for k < `LEAD_LEN`, and `LOOP_PAT[(k-LEAD_LEN) mod LOOP_LEN]` after that. With the defaults the letters run 0,1,1 and then 1,0,1,1,0 repeated.
- R3: `out_vld` is high only on cycles whose letter is 1. On such a cycle it stays low if the slot is empty and no token arrives.
- R4: On a 1-letter cycle with a token held, `out_vld` is high and `out_data` is the held token.
- R5: On a 1-letter cycle with the slot empty and a token arriving, that token appears on `out_data` in the same cycle and is not stored.
- R6: A token arriving on a 0-letter cycle is stored in the slot. It stays there over any further 0-letter cycles. A token arriving while the slot is full on a 0-letter cycle is an overflow.
- R7: On a 1-letter cycle with a token held and a new token arriving, the held token is sent and the new token takes the slot.
- R8: With no overflow, every token that enters leaves exactly once, in arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 1 | Token present from the link register |
| in_data | input | DATA_W | Token value |
| out_vld | output | 1 | Token delivered to the consumer this cycle |
| out_data | output | DATA_W | Delivered token value |

## Verification
Delivery is combinational from the slot and the arriving token. A pass-through or a held token is therefore due in the same cycle as the 1 letter, and the bench samples 1.5 ns after driving inputs at the falling edge. A token captured on a 0 letter is due on the next 1-letter cycle, one or more cycles later. The bench's vector table lists the expected output for every cycle so that this wait is checked exactly. The state that reset clears is observed in the first two cycles after release: a token still held from before the reset would show up on the 1 letter of cycle 1.

// File: rtl/frac_pkg.sv
package frac_pkg;
    typedef enum logic {PH_LEAD, PH_LOOP} phase_t;
    typedef enum logic {SL_EMPTY, SL_HELD} slot_t;
endpackage

// File: rtl/frac_sched_seq.sv
module frac_sched_seq
    import frac_pkg::*;
#(
    parameter int MAX_LEN  = 32,
    parameter int LEAD_LEN = 3,
    parameter int LOOP_LEN = 5,
    parameter logic [MAX_LEN-1:0] LEAD_PAT = 32'b110,
    parameter logic [MAX_LEN-1:0] LOOP_PAT = 32'b01101
) (
    input  logic clk,
    input  logic rst,
    output logic fire
);
    localparam int IW = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1;
    localparam logic [IW-1:0] LEAD_LAST = IW'((LEAD_LEN > 0) ? LEAD_LEN - 1 : 0);
    localparam logic [IW-1:0] LOOP_LAST = IW'(LOOP_LEN - 1);

    phase_t        ph, ph_nx;
    logic [IW-1:0] idx, idx_nx;
    phase_t        start_ph;

    generate
        if (LEAD_LEN > 0) begin : g_lead
            assign start_ph = PH_LEAD;
        end else begin : g_nolead
            assign start_ph = PH_LOOP;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            ph  <= start_ph;
            idx <= '0;
        end else begin
            ph  <= ph_nx;
            idx <= idx_nx;
        end
    end

    always_comb begin
        ph_nx  = ph;
        idx_nx = idx + IW'(1);
        unique case (ph)
            PH_LEAD: begin
                if (idx == LEAD_LAST) begin
                    ph_nx  = PH_LOOP;
                    idx_nx = '0;
                end
            end
            PH_LOOP: begin
                if (idx == LOOP_LAST) idx_nx = '0;
            end
        endcase
    end

    always_comb begin
        unique case (ph)
            PH_LEAD: fire = LEAD_PAT[idx];
            PH_LOOP: fire = LOOP_PAT[idx];
        endcase
    end
endmodule

// File: rtl/frac_slot.sv
module frac_slot
    import frac_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fire,
    input  logic          in_vld,
    input  logic [DW-1:0] in_data,
    output logic          raw_vld,
    output logic [DW-1:0] out_data,
    output logic          full,
    output logic [DW-1:0] held
);
    slot_t st, st_nx;
    logic  load;

    always_ff @(posedge clk) begin
        if (rst) st <= SL_EMPTY;
        else     st <= st_nx;
    end

    always_ff @(posedge clk) begin
        if (load) held <= in_data;
    end

    always_comb begin
        st_nx = st;
        load  = 1'b0;
        unique case (st)
            SL_EMPTY: begin
                if (in_vld && !fire) begin
                    st_nx = SL_HELD;
                    load  = 1'b1;
                end
            end
            SL_HELD: begin
                if (fire && in_vld)  load  = 1'b1;
                if (fire && !in_vld) st_nx = SL_EMPTY;
            end
        endcase
    end

    always_comb begin
        unique case (st)
            SL_EMPTY: begin
                raw_vld  = fire & in_vld;
                out_data = in_data;
            end
            SL_HELD: begin
                raw_vld  = fire;
                out_data = held;
            end
        endcase
    end

    assign full = (st == SL_HELD);
endmodule

// File: rtl/frac_reg.sv
module frac_reg #(
    parameter int DATA_W   = 8,
    parameter int MAX_LEN  = 32,
    parameter int LEAD_LEN = 3,
    parameter int LOOP_LEN = 5,
    parameter logic [MAX_LEN-1:0] LEAD_PAT = 32'b110,
    parameter logic [MAX_LEN-1:0] LOOP_PAT = 32'b01101
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_vld,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_vld,
    output logic [DATA_W-1:0] out_data
);
    logic              fire;
    logic              raw_vld;
    logic              slot_full;
    logic [DATA_W-1:0] slot_data;

    frac_sched_seq #(
        .MAX_LEN (MAX_LEN),
        .LEAD_LEN(LEAD_LEN),
        .LOOP_LEN(LOOP_LEN),
        .LEAD_PAT(LEAD_PAT),
        .LOOP_PAT(LOOP_PAT)
    ) u_seq (
        .clk (clk),
        .rst (rst),
        .fire(fire)
    );

    frac_slot #(.DW(DATA_W)) u_slot (
        .clk     (clk),
        .rst     (rst),
        .fire    (fire),
        .in_vld  (in_vld),
        .in_data (in_data),
        .raw_vld (raw_vld),
        .out_data(out_data),
        .full    (slot_full),
        .held    (slot_data)
    );

    assign out_vld = raw_vld & ~rst;
endmodule

// File: rtl/frac_reg_chk.sv
module frac_reg_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          in_vld,
    input logic [DW-1:0] in_data,
    input logic          out_vld,
    input logic [DW-1:0] out_data,
    input logic          fire,
    input logic          slot_full,
    input logic [DW-1:0] slot_data
);
    // R1
    always @(posedge clk) begin
        if (rst) reset_quiet_chk: assert (!out_vld);
    end

    // R3
    only_on_fire_chk: assert property (@(posedge clk) disable iff (rst)
        out_vld |-> fire);

    // R6
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        !(in_vld && slot_full && !fire));

    // R6
    capture_chk: assert property (@(posedge clk) disable iff (rst)
        (in_vld && !fire && !slot_full) |=> (slot_full && slot_data == $past(in_data)));

    // R6
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (slot_full && !fire && !in_vld) |=> (slot_full && $stable(slot_data)));

    // R5
    pass_chk: assert property (@(posedge clk) disable iff (rst)
        (in_vld && fire && !slot_full) |-> (out_vld && out_data == in_data));

    // R7
    swap_chk: assert property (@(posedge clk) disable iff (rst)
        (slot_full && fire && in_vld) |=> (slot_full && slot_data == $past(in_data)));
endmodule

bind frac_reg frac_reg_chk #(.DW(DATA_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_vld   (in_vld),
    .in_data  (in_data),
    .out_vld  (out_vld),
    .out_data (out_data),
    .fire     (fire),
    .slot_full(slot_full),
    .slot_data(slot_data)
);

// File: tb/sim_frac_reg.sv
`timescale 1ns/1ps
module sim_frac_reg;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_vld = 1'b0;
    logic [7:0] in_data = '0;
    logic       out_vld;
    logic [7:0] out_data;
    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    frac_reg u0 (
        .clk(clk), .rst(rst), .in_vld(in_vld), .in_data(in_data),
        .out_vld(out_vld), .out_data(out_data)
    );

    // {tag code[2:0], in_vld, in_data[7:0], exp_vld, exp_data[7:0]}
    localparam logic [20:0] VEC [19] = '{
        {3'd6, 1'b1, 8'hA1, 1'b0, 8'h00},  // c0  letter 0
        {3'd4, 1'b0, 8'h00, 1'b1, 8'hA1},  // c1  letter 1
        {3'd5, 1'b1, 8'hB2, 1'b1, 8'hB2},  // c2  letter 1
        {3'd5, 1'b1, 8'hC3, 1'b1, 8'hC3},  // c3  letter 1
        {3'd6, 1'b1, 8'hD4, 1'b0, 8'h00},  // c4  letter 0
        {3'd7, 1'b1, 8'hE5, 1'b1, 8'hD4},  // c5  letter 1
        {3'd4, 1'b0, 8'h00, 1'b1, 8'hE5},  // c6  letter 1
        {3'd3, 1'b0, 8'h00, 1'b0, 8'h00},  // c7  letter 0
        {3'd3, 1'b0, 8'h00, 1'b0, 8'h00},  // c8  letter 1, nothing
        {3'd6, 1'b1, 8'hF6, 1'b0, 8'h00},  // c9  letter 0
        {3'd4, 1'b0, 8'h00, 1'b1, 8'hF6},  // c10 letter 1
        {3'd3, 1'b0, 8'h00, 1'b0, 8'h00},  // c11 letter 1, nothing
        {3'd6, 1'b1, 8'h07, 1'b0, 8'h00},  // c12 letter 0
        {3'd7, 1'b1, 8'h08, 1'b1, 8'h07},  // c13 letter 1
        {3'd6, 1'b0, 8'h00, 1'b0, 8'h00},  // c14 letter 0, keep 08
        {3'd4, 1'b0, 8'h00, 1'b1, 8'h08},  // c15 letter 1
        {3'd5, 1'b1, 8'h09, 1'b1, 8'h09},  // c16 letter 1
        {3'd3, 1'b0, 8'h00, 1'b0, 8'h00},  // c17 letter 0
        {3'd3, 1'b0, 8'h00, 1'b0, 8'h00}   // c18 letter 1, nothing
    };

    function automatic string tag_of(input logic [2:0] c);
        case (c)
            3'd3:    return "R3";
            3'd4:    return "R4";
            3'd5:    return "R5";
            3'd6:    return "R6";
            default: return "R7";
        endcase
    endfunction

    // R2 default schedule: lead 0,1,1 then loop 1,0,1,1,0
    function automatic logic exp_letter(input int k);
        logic [2:0] lead = 3'b110;
        logic [4:0] loop = 5'b01101;
        if (k < 3) return lead[k];
        return loop[(k - 3) % 5];
    endfunction

    task automatic chk(input string tag, input logic ev, input logic [7:0] ed);
        checks++;
        if (out_vld !== ev || (ev && out_data !== ed)) begin
            fails++;
            $display("FAIL %s: got vld=%0b data=%h, expected vld=%0b data=%h",
                     tag, out_vld, out_data, ev, ed);
        end
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int nin = 0;
        int nout = 0;
        logic [2:0] tc;
        logic iv, ev;
        logic [7:0] id, ed;

        repeat (3) @(negedge clk);
        in_vld = 1'b1; in_data = 8'h3C;
        #1.5 chk("R1", 1'b0, 8'h00);
        @(negedge clk);
        rst = 1'b0;
        for (int k = 0; k < 19; k++) begin
            {tc, iv, id, ev, ed} = VEC[k];
            in_vld = iv; in_data = id;
            #1.5 chk(tag_of(tc), ev, ed);
            if (in_vld) nin++;
            if (out_vld) nout++;
            @(negedge clk);
        end
        checks++;
        if (nin != nout) begin
            fails++;
            $display("FAIL R8: got %0d tokens out, expected %0d", nout, nin);
        end

        // cycle 19 is a 0 letter: park a token, then reset over it
        in_vld = 1'b1; in_data = 8'hAA;
        #1.5 chk("R6", 1'b0, 8'h00);
        @(negedge clk);
        rst = 1'b1; in_vld = 1'b1; in_data = 8'h11;
        #1.5 chk("R1", 1'b0, 8'h00);
        @(negedge clk);
        rst = 1'b0; in_vld = 1'b0;
        #1.5 chk("R1", 1'b0, 8'h00);
        @(negedge clk);
        #1.5 chk("R1", 1'b0, 8'h00);   // letter 1: slot must be empty
        @(negedge clk);
        in_vld = 1'b1; in_data = 8'h55;
        #1.5 chk("R2", 1'b1, 8'h55);
        @(negedge clk);

        // several loop periods, token offered only on 1 letters
        for (int k = 3; k < 63; k++) begin
            in_vld = exp_letter(k); in_data = 8'(k);
            #1.5 chk("R2", exp_letter(k), 8'(k));
            @(negedge clk);
        end
        in_vld = 1'b0;

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule